// File: doc/BRIEF.md
# Address-space-tagged translation buffer controller

This block holds a small, fully associative set of virtual-to-physical page translations and is managed entirely through a register-write port. Software stages a page-table word and a current address-space number, then issues an insert command whose data carries the virtual address. The new entry is built from the staged fields plus the staged address-space number. Three invalidation commands are available: every entry, every entry not marked global, or the single page that matches the written virtual address within the current address space.

A separate combinational lookup port takes a virtual page number and an address-space number. It returns a hit flag, the physical page number, the read and write enable masks, and the two fault-on-access flags. An entry marked global matches under any address-space number. Inserts that carry a non-zero granularity hint are refused and raise a one-cycle error flag.

Top module: `xb_ctrl`

## Requirements
- R1: After reset every entry is invalid, every lookup misses and `ins_err` is 0.
- R2: Command selects on `cfg_sel` are 0 = address-space write, 1 = page-table stage, 2 = insert, 3 = flush all, 4 = flush non-global and 5 = flush one page. Codes 6 and 7 do nothing. The address-space write keeps only `cfg_data[63:57]`. The staged page-table word gives the physical page from bits 58:32, the read mask from bits 11:8, the write mask from bits 15:12, fault-on-read from bit 1, fault-on-write from bit 2, global from bit 4 and the granularity hint from bits 6:5. An insert stores these fields with the current address-space number under the virtual page `cfg_data[32:13]`.
- R3: A lookup hits when a valid entry has the same virtual page and is either global or has the same address-space number. The outputs then carry that entry's fields; with several hits, the lowest-numbered entry wins. On a miss all lookup data outputs are 0.
- R4: An insert whose staged granularity hint is non-zero changes no entry and does not move the victim pointer. `ins_err` is 1 for exactly the cycle after that insert and 0 otherwise.
- R5: A flush-all write invalidates every entry whatever data it carries.
- R6: A flush-non-global write invalidates exactly the entries whose global bit is 0.
- R7: A flush-one write invalidates only valid entries whose virtual page equals `cfg_data[32:13]` and whose address-space number equals the current one. A global entry with another number survives.
- R8: There are 8 entries. An accepted insert that matches no existing entry goes to the victim pointer, which starts at 0 and steps 0..7 cyclically. The ninth distinct insert therefore replaces the first.
- R9: An accepted insert whose virtual page and current address-space number equal those of a valid entry rewrites that entry in place and does not step the victim pointer.
- R10: Inserts and invalidations take effect at the clock edge that samples the write. A lookup in the same cycle returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Command write strobe |
| cfg_sel | input | 3 | Command select |
| cfg_data | input | 64 | Command data |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asn | input | 7 | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 27 | Physical page number of the hit |
| lk_rd_en | output | 4 | Read enable mask |
| lk_wr_en | output | 4 | Write enable mask |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |
| ins_err | output | 1 | Refused insert, one cycle |

## Verification
The buffer is filled with eight entries whose fields follow an arithmetic pattern, mixing global and per-process entries. Every entry is then looked up under its own address-space number and under a foreign one, which separates the global match from the number match. Further inserts past the eighth, plus re-inserts of an existing page, separate round-robin eviction from in-place rewriting. Flush-one is tried under a wrong and a right current number, and flush-non-global and flush-all are swept over the full contents. A lookup held across the flush edge shows that the old contents stay visible until that edge.

// File: rtl/xb_pkg.sv
package xb_pkg;
    localparam int PPN_W  = 27;
    localparam int PERM_W = 4;
    localparam int ASN_W  = 7;
    localparam int GH_W   = 2;

    localparam int PPN_LSB  = 32;
    localparam int RD_LSB   = 8;
    localparam int WR_LSB   = 12;
    localparam int FRD_BIT  = 1;
    localparam int FWR_BIT  = 2;
    localparam int GBL_BIT  = 4;
    localparam int GH_LSB   = 5;
    localparam int ASN_LSB  = 57;

    typedef enum logic [2:0] {
        CMD_ASN        = 3'd0,
        CMD_PTE        = 3'd1,
        CMD_INSERT     = 3'd2,
        CMD_FLUSH_ALL  = 3'd3,
        CMD_FLUSH_PROC = 3'd4,
        CMD_FLUSH_ONE  = 3'd5
    } xb_cmd_e;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] rd;
        logic [PERM_W-1:0] wr;
        logic              frd;
        logic              fwr;
        logic              gbl;
    } xb_attr_t;
endpackage

// File: rtl/xb_victim.sv
module xb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R8: pointer only moves on an accepted fresh insert
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ptr != $past(ptr));
endmodule

// File: rtl/xb_entry_array.sv
module xb_entry_array
    import xb_pkg::*;
#(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [ASN_W-1:0] wr_asn,
    input  xb_attr_t         wr_attr,
    input  logic             inv_all,
    input  logic             inv_proc,
    input  logic             inv_one,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic [N-1:0]     hit_vec,
    output logic [N-1:0]     same_vec,
    output logic [N-1:0]     valid_vec,
    output logic [N-1:0]     gbl_vec,
    output xb_attr_t         attr_arr [N]
);
    logic [VPN_W-1:0] vpn_q [N];
    logic [ASN_W-1:0] asn_q [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic drop;
        assign drop = inv_all
                    | (inv_proc & ~attr_arr[i].gbl)
                    | (inv_one & (vpn_q[i] == wr_vpn) & (asn_q[i] == wr_asn));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[i] <= 1'b0;
                vpn_q[i]     <= '0;
                asn_q[i]     <= '0;
                attr_arr[i]  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                valid_vec[i] <= 1'b1;
                vpn_q[i]     <= wr_vpn;
                asn_q[i]     <= wr_asn;
                attr_arr[i]  <= wr_attr;
            end else if (drop) begin
                valid_vec[i] <= 1'b0;
            end
        end

        assign hit_vec[i]  = valid_vec[i] & (vpn_q[i] == lk_vpn)
                           & (attr_arr[i].gbl | (asn_q[i] == lk_asn));
        assign same_vec[i] = valid_vec[i] & (vpn_q[i] == wr_vpn)
                           & (asn_q[i] == wr_asn);
        assign gbl_vec[i]  = attr_arr[i].gbl;
    end

    // R5: flush-all leaves nothing valid
    a_r5_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> valid_vec == '0);
    // R6: flush-non-global leaves only global entries
    a_r6_flush_proc: assert property (@(posedge clk) disable iff (!rst_n)
        inv_proc |=> (valid_vec & ~gbl_vec) == '0);
endmodule

// File: rtl/xb_pick.sv
module xb_pick
    import xb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] hit_vec,
    input  xb_attr_t     attr_arr [N],
    output logic         hit,
    output xb_attr_t     attr
);
    always_comb begin
        attr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i])
                attr = attr_arr[i];
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/xb_ctrl.sv
module xb_ctrl
    import xb_pkg::*;
#(
    parameter int N_ENT      = 8,
    parameter int VPN_W      = 20,
    parameter int PAGE_SHIFT = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [63:0]         cfg_data,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic [ASN_W-1:0]    lk_asn,
    output logic                lk_hit,
    output logic [PPN_W-1:0]    lk_ppn,
    output logic [PERM_W-1:0]   lk_rd_en,
    output logic [PERM_W-1:0]   lk_wr_en,
    output logic                lk_fault_rd,
    output logic                lk_fault_wr,
    output logic                ins_err
);
    localparam int IDX_W = $clog2(N_ENT);

    xb_cmd_e cmd;
    logic    do_asn, do_pte, do_ins, do_fall, do_fproc, do_fone;

    assign cmd = xb_cmd_e'(cfg_sel);

    always_comb begin
        do_asn   = 1'b0;
        do_pte   = 1'b0;
        do_ins   = 1'b0;
        do_fall  = 1'b0;
        do_fproc = 1'b0;
        do_fone  = 1'b0;
        if (cfg_we) begin
            unique case (cmd)
                CMD_ASN:        do_asn   = 1'b1;
                CMD_PTE:        do_pte   = 1'b1;
                CMD_INSERT:     do_ins   = 1'b1;
                CMD_FLUSH_ALL:  do_fall  = 1'b1;
                CMD_FLUSH_PROC: do_fproc = 1'b1;
                CMD_FLUSH_ONE:  do_fone  = 1'b1;
                default: ;
            endcase
        end
    end

    // staged registers
    logic [ASN_W-1:0] asn_r;
    xb_attr_t         pte_r;
    logic [GH_W-1:0]  gh_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asn_r <= '0;
            pte_r <= '0;
            gh_r  <= '0;
        end else begin
            if (do_asn)
                asn_r <= cfg_data[ASN_LSB +: ASN_W];
            if (do_pte) begin
                pte_r.ppn <= cfg_data[PPN_LSB +: PPN_W];
                pte_r.rd  <= cfg_data[RD_LSB +: PERM_W];
                pte_r.wr  <= cfg_data[WR_LSB +: PERM_W];
                pte_r.frd <= cfg_data[FRD_BIT];
                pte_r.fwr <= cfg_data[FWR_BIT];
                pte_r.gbl <= cfg_data[GBL_BIT];
                gh_r      <= cfg_data[GH_LSB +: GH_W];
            end
        end
    end

    // insert / flush datapath
    logic [VPN_W-1:0] va_vpn;
    logic             ins_ok, ins_bad, same_any, adv;
    logic [IDX_W-1:0] same_idx, vict_idx, wr_idx;
    logic [N_ENT-1:0] hit_vec, same_vec, valid_vec, gbl_vec;
    xb_attr_t         attr_arr [N_ENT];
    xb_attr_t         lk_attr;

    assign va_vpn   = cfg_data[PAGE_SHIFT +: VPN_W];
    assign ins_ok   = do_ins & (gh_r == '0);
    assign ins_bad  = do_ins & (gh_r != '0);
    assign same_any = |same_vec;

    always_comb begin
        same_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (same_vec[i])
                same_idx = IDX_W'(i);
        end
    end

    assign adv    = ins_ok & ~same_any;
    assign wr_idx = same_any ? same_idx : vict_idx;

    xb_victim #(.N(N_ENT), .IDX_W(IDX_W)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .ptr   (vict_idx)
    );

    xb_entry_array #(.N(N_ENT), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ins_ok),
        .wr_idx    (wr_idx),
        .wr_vpn    (va_vpn),
        .wr_asn    (asn_r),
        .wr_attr   (pte_r),
        .inv_all   (do_fall),
        .inv_proc  (do_fproc),
        .inv_one   (do_fone),
        .lk_vpn    (lk_vpn),
        .lk_asn    (lk_asn),
        .hit_vec   (hit_vec),
        .same_vec  (same_vec),
        .valid_vec (valid_vec),
        .gbl_vec   (gbl_vec),
        .attr_arr  (attr_arr)
    );

    xb_pick #(.N(N_ENT)) u_pick (
        .hit_vec  (hit_vec),
        .attr_arr (attr_arr),
        .hit      (lk_hit),
        .attr     (lk_attr)
    );

    assign lk_ppn      = lk_attr.ppn;
    assign lk_rd_en    = lk_attr.rd;
    assign lk_wr_en    = lk_attr.wr;
    assign lk_fault_rd = lk_attr.frd;
    assign lk_fault_wr = lk_attr.fwr;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ins_err <= 1'b0;
        else
            ins_err <= ins_bad;
    end

    // R4: refused insert raises the flag and touches no entry
    a_r4_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ins_bad |=> ins_err);
    a_r4_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        ins_bad |=> $stable(valid_vec));
    a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_bad |=> !ins_err);
endmodule

// File: tb/xb_ctrl_test.sv
module xb_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [63:0] cfg_data = '0;
    logic [19:0] lk_vpn = '0;
    logic [6:0]  lk_asn = '0;
    logic        lk_hit, lk_fault_rd, lk_fault_wr, ins_err;
    logic [26:0] lk_ppn;
    logic [3:0]  lk_rd_en, lk_wr_en;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xb_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
        .lk_wr_en(lk_wr_en), .lk_fault_rd(lk_fault_rd),
        .lk_fault_wr(lk_fault_wr), .ins_err(ins_err)
    );

    // reference model, built from the requirements
    logic        m_v   [N];
    logic [19:0] m_vpn [N];
    logic [6:0]  m_asn [N];
    logic [37:0] m_f   [N];   // {ppn, rd, wr, frd, fwr}
    logic        m_g   [N];
    int          m_ptr;
    logic [63:0] m_pte;
    logic [6:0]  m_asnr;

    function automatic logic [63:0] mk_pte(input logic [26:0] ppn,
        input logic [3:0] rd, input logic [3:0] wr, input logic frd,
        input logic fwr, input logic g, input logic [1:0] gh);
        logic [63:0] p;
        p = 64'h0;
        p[58:32] = ppn; p[11:8] = rd; p[15:12] = wr;
        p[1] = frd; p[2] = fwr; p[4] = g; p[6:5] = gh;
        p[0] = 1'b1; p[3] = 1'b1;  // unused bits set on purpose
        return p;
    endfunction

    function automatic logic [63:0] va_of(input logic [19:0] vpn);
        return {31'h0, vpn, 13'h1abc};
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_cmd(input logic [2:0] sel, input logic [63:0] d);
        logic [19:0] vpn;
        int idx;
        vpn = d[32:13];
        case (sel)
            3'd0: m_asnr = d[63:57];
            3'd1: m_pte = d;
            3'd2: if (m_pte[6:5] == 2'b00) begin
                idx = -1;
                for (int i = N - 1; i >= 0; i--)
                    if (m_v[i] && m_vpn[i] == vpn && m_asn[i] == m_asnr) idx = i;
                if (idx < 0) begin idx = m_ptr; m_ptr = (m_ptr + 1) % N; end
                m_v[idx] = 1'b1; m_vpn[idx] = vpn; m_asn[idx] = m_asnr;
                m_g[idx] = m_pte[4];
                m_f[idx] = {m_pte[58:32], m_pte[11:8], m_pte[15:12], m_pte[1], m_pte[2]};
            end
            3'd3: for (int i = 0; i < N; i++) m_v[i] = 1'b0;
            3'd4: for (int i = 0; i < N; i++) if (!m_g[i]) m_v[i] = 1'b0;
            3'd5: for (int i = 0; i < N; i++)
                      if (m_vpn[i] == vpn && m_asn[i] == m_asnr) m_v[i] = 1'b0;
            default: ;
        endcase
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_cmd(sel, d);
    endtask

    task automatic look(input string req, input logic [19:0] vpn,
                        input logic [6:0] asn);
        logic eh;
        logic [37:0] ef;
        eh = 1'b0; ef = '0;
        for (int i = N - 1; i >= 0; i--)
            if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asn[i] == asn)) begin
                eh = 1'b1; ef = m_f[i];
            end
        lk_vpn = vpn; lk_asn = asn;
        #1;
        check(req, {63'h0, lk_hit}, {63'h0, eh});
        check(req, {26'h0, lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr},
              {26'h0, ef});
    endtask

    function automatic logic [19:0] pat_vpn(input int k);
        return 20'h01000 + 20'(k * 37);
    endfunction

    task automatic stage_pat(input int k, input logic [1:0] gh);
        cfg(3'd1, mk_pte(27'h0001234 ^ 27'(k << 20) ^ 27'(k * 5),
            4'(k + 1), ~4'(k), k[0], k[1], (k % 3) == 0, gh));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_vpn[i] = 0; m_asn[i] = 0; m_f[i] = 0; m_g[i] = 0;
        end
        m_ptr = 0; m_pte = 0; m_asnr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 ins_err", {63'h0, ins_err}, 64'h0);
        for (int k = 0; k < N; k++) look("R1 reset miss", pat_vpn(k), 7'd0);

        // R2: address-space write keeps only the top 7 bits
        cfg(3'd0, {7'd5, 57'h1ff_ffff_ffff_ffff});
        for (int k = 0; k < N; k++) begin
            stage_pat(k, 2'b00);
            cfg(3'd2, va_of(pat_vpn(k)));
        end
        for (int k = 0; k < N; k++) begin
            look("R2 fields own asn", pat_vpn(k), 7'd5);
            look("R3 foreign asn global-only", pat_vpn(k), 7'd6);
        end
        look("R3 unknown page", 20'hfffff, 7'd5);

        // R9: rewrite in place (entry 3) keeps pointer
        stage_pat(11, 2'b00);
        cfg(3'd2, va_of(pat_vpn(3)));
        look("R9 rewritten entry", pat_vpn(3), 7'd5);
        // R8: next fresh insert evicts entry 0
        stage_pat(12, 2'b00);
        cfg(3'd2, va_of(20'h0abcd));
        look("R8 new entry", 20'h0abcd, 7'd5);
        look("R8 evicted oldest", pat_vpn(0), 7'd5);
        look("R8 second kept", pat_vpn(1), 7'd5);
        // R8: same page under another number is a fresh entry
        cfg(3'd0, {7'd9, 57'h0});
        stage_pat(13, 2'b00);
        cfg(3'd2, va_of(pat_vpn(2)));
        look("R8 second slot replaced", pat_vpn(1), 7'd5);
        look("R8 per-asn copy", pat_vpn(2), 7'd9);

        // R4: refused insert
        stage_pat(14, 2'b10);
        cfg(3'd2, va_of(20'h0beef));
        check("R4 err pulse", {63'h0, ins_err}, 64'h1);
        look("R4 no entry written", 20'h0beef, 7'd9);
        @(negedge clk);
        check("R4 err one cycle", {63'h0, ins_err}, 64'h0);
        stage_pat(15, 2'b00);
        cfg(3'd2, va_of(20'h0beef));
        check("R4 no err on good insert", {63'h0, ins_err}, 64'h0);
        look("R4 pointer not moved", pat_vpn(2), 7'd5);
        look("R4 good insert", 20'h0beef, 7'd9);

        // R2: codes 6 and 7 do nothing
        cfg(3'd6, 64'hffff_ffff_ffff_ffff);
        cfg(3'd7, 64'hffff_ffff_ffff_ffff);
        for (int k = 0; k < N; k++) look("R2 idle codes", pat_vpn(k), 7'd5);

        // R7: flush one under wrong then right number
        cfg(3'd0, {7'd6, 57'h0});
        cfg(3'd5, va_of(pat_vpn(4)));
        look("R7 wrong asn kept", pat_vpn(4), 7'd5);
        cfg(3'd0, {7'd5, 57'h0});
        cfg(3'd5, va_of(pat_vpn(4)));
        look("R7 page removed", pat_vpn(4), 7'd5);
        look("R7 neighbour kept", pat_vpn(5), 7'd5);
        cfg(3'd0, {7'd6, 57'h0});
        cfg(3'd5, va_of(pat_vpn(6)));
        look("R7 global other asn kept", pat_vpn(6), 7'd6);

        // R6: flush non-global
        cfg(3'd4, 64'h0);
        for (int k = 0; k < N; k++) begin
            look("R6 sweep", pat_vpn(k), 7'd5);
            look("R6 sweep foreign", pat_vpn(k), 7'd6);
        end
        look("R6 sweep extra", 20'h0beef, 7'd9);

        // R10: lookup in the flush cycle sees old contents
        @(negedge clk);
        lk_vpn = pat_vpn(6); lk_asn = 7'd5;
        cfg_we = 1'b1; cfg_sel = 3'd3; cfg_data = 64'h1234;
        #1;
        check("R10 old contents", {63'h0, lk_hit}, 64'h1);
        @(negedge clk);
        cfg_we = 1'b0;
        model_cmd(3'd3, 64'h1234);
        #1;
        check("R10 applied at edge", {63'h0, lk_hit}, 64'h0);

        // R5: everything gone
        for (int k = 0; k < N; k++) look("R5 flush all", pat_vpn(k), 7'd5);
        look("R5 flush all extra", 20'h0abcd, 7'd5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule